// File: doc/BRIEF.md
# Pad Wake-Up Detect Configurator

This block holds the wake-up detect settings for a bank of pads. It is built as nine ports of eight pins, 72 pads in total. Each pad has four settings: a sense polarity, a wake enable, and two weak-pull selects. None of these is written directly. Software first raises the pad's bit in a request word and waits until the matching acknowledge word has caught up with it. It then loads a control word that names one pad, picks a mode and sets an enable bit. Last, it writes one of two pulse strobes. What a strobe does depends on the mode.

Once a pad is wake-enabled, its input is compared against the configured active level on every clock edge. When the pad matches for two consecutive edges, its sticky seen bit is set. The wake output is raised while any seen bit is set. The seen bits can be read back, packed in the same word layout as the requests. Two global clear strobes are provided: one empties the seen latches, the other resets every pad setting.

Top module: `pad_wake_cfg`

## Requirements
- R1: After reset the request, acknowledge, control, seen, wake-enable, polarity and pull state are all zero. The wake output is low.
- R2: Request words are read and written at addresses 0 to 2. The request bit of pad `port*8+pin` sits in word `port/4` at bit `(port%4)*8+pin`. Each acknowledge word (addresses 4 to 6) takes the value of its request word one cycle after that word changes.
- R3: The control word is at address 8: pad index in bits [7:0], mode in bits [9:8], enable in bit 15. A pulse0 write (address 9) or a pulse1 write (address 10) changes a setting only under all of these conditions: the control enable is set, the pad index is below 72, the selected pad's request bit is set, and its acknowledge word equals its request word. Any other pulse is ignored.
- R4: In mode 0 (sense), pulse0 makes the selected pad active-high and pulse1 makes it active-low.
- R5: In mode 1 (wake enable), pulse1 enables wake on the selected pad and pulse0 disables it.
- R6: In mode 2 (weak pull), pulse0 selects pull-up and pulse1 selects pull-down. Either choice clears the other bit, shown on outputs `pull_up` and `pull_dn`. The two bits are never both set for the same pad.
- R7: A wake-enabled pad sets its seen bit at the second consecutive clock edge at which its input equals its active level. A match that lasts for only one edge sets nothing. A pad that is not wake-enabled never sets its seen bit.
- R8: Seen bits are read at addresses 12 to 14 in the R2 layout and are also driven on `seen`. Unused bits read as zero.
- R9: `wake` is high exactly when at least one seen bit is set.
- R10: A write to address 15 with bit 0 set clears all seen bits. With bit 1 set it clears every pad's polarity, wake enable and pull settings. Neither clear touches the request words.
- R11: A pulse in mode 3 changes no setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pad_in | input | 72 | Pad input levels, index port*8+pin |
| wake | output | 1 | Any pad has been seen |
| seen | output | 72 | Per-pad seen latches |
| pull_up | output | 72 | Weak pull-up selected |
| pull_dn | output | 72 | Weak pull-down selected |

## Verification
Results fall due at different times. A register write takes effect at the edge that samples it, so request, control and pad settings read back and the pull outputs show the new value at the following falling edge. An acknowledge word trails its request by one extra edge, so a pulse issued right after a request write is expected to be ignored. Seen bits and `wake` change at the second matching edge. The bench drives all inputs at falling edges and keeps a reference model that it updates at rising edges from the same bus and pad values. It then compares every output and the read data at the next falling edge, which is the first point where each result is due.

// File: rtl/pad_wake_cfg.sv
module pad_wake_cfg #(
  parameter int NPORT = 9,
  parameter int PINS  = 8,
  parameter int PPW   = 4,
  parameter int AW    = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bus_wr,
  input  logic [AW-1:0]          bus_addr,
  input  logic [PINS*PPW-1:0]    bus_wdata,
  output logic [PINS*PPW-1:0]    bus_rdata,
  input  logic [NPORT*PINS-1:0]  pad_in,
  output logic                   wake,
  output logic [NPORT*PINS-1:0]  seen,
  output logic [NPORT*PINS-1:0]  pull_up,
  output logic [NPORT*PINS-1:0]  pull_dn
);
  localparam int DW    = PINS * PPW;
  localparam int NPAD  = NPORT * PINS;
  localparam int NWORD = (NPORT + PPW - 1) / PPW;
  localparam int NBIT  = NWORD * DW;
  localparam logic [AW-1:0] A_REQ  = 0;
  localparam logic [AW-1:0] A_ACK  = 4;
  localparam logic [AW-1:0] A_CTRL = 8;
  localparam logic [AW-1:0] A_P0   = 9;
  localparam logic [AW-1:0] A_P1   = 10;
  localparam logic [AW-1:0] A_SEEN = 12;
  localparam logic [AW-1:0] A_CLR  = 15;

  logic [NBIT-1:0]  req_q, ack_q, seen_w;
  logic [15:0]      ctrl_q;
  logic [NPAD-1:0]  wen_q, actlo_q, pu_q, pd_q, seen_q, hit_q, match, sel_oh;
  logic [NWORD-1:0] word_ok;
  logic [7:0]       sel;
  logic [1:0]       mode;
  logic             p0, p1, do_cfg, sel_ok, ev_clr, cfg_clr;

  for (genvar w = 0; w < NWORD; w++) begin : g_ok
    assign word_ok[w] = ack_q[w*DW +: DW] == req_q[w*DW +: DW];
  end

  assign sel     = ctrl_q[7:0];
  assign mode    = ctrl_q[9:8];
  assign sel_ok  = int'(sel) < NPAD;
  assign p0      = bus_wr && bus_addr == A_P0;
  assign p1      = bus_wr && bus_addr == A_P1;
  assign ev_clr  = bus_wr && bus_addr == A_CLR && bus_wdata[0];
  assign cfg_clr = bus_wr && bus_addr == A_CLR && bus_wdata[1];
  assign do_cfg  = (p0 || p1) && ctrl_q[15] && sel_ok && req_q[sel] && word_ok[int'(sel) / DW];
  assign sel_oh  = do_cfg ? (NPAD'(1) << sel) : '0;
  assign match   = pad_in ^ actlo_q;
  assign seen_w  = NBIT'(seen_q);

  assign seen    = seen_q;
  assign wake    = |seen_q;
  assign pull_up = pu_q;
  assign pull_dn = pd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= '0;
      ack_q  <= '0;
      ctrl_q <= '0;
    end else begin
      ack_q <= req_q;
      if (bus_wr && int'(bus_addr) < NWORD)
        req_q[int'(bus_addr)*DW +: DW] <= bus_wdata;
      if (bus_wr && bus_addr == A_CTRL)
        ctrl_q <= bus_wdata[15:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wen_q   <= '0;
      actlo_q <= '0;
      pu_q    <= '0;
      pd_q    <= '0;
    end else if (cfg_clr) begin
      wen_q   <= '0;
      actlo_q <= '0;
      pu_q    <= '0;
      pd_q    <= '0;
    end else if (do_cfg) begin
      case (mode)
        2'd0: actlo_q <= (actlo_q & ~sel_oh) | (p1 ? sel_oh : '0);
        2'd1: wen_q   <= (wen_q & ~sel_oh) | (p1 ? sel_oh : '0);
        2'd2: begin
          pu_q <= (pu_q & ~sel_oh) | (p0 ? sel_oh : '0);
          pd_q <= (pd_q & ~sel_oh) | (p1 ? sel_oh : '0);
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_q  <= '0;
      seen_q <= '0;
    end else begin
      hit_q  <= match & wen_q;
      seen_q <= ev_clr ? '0 : (seen_q | (hit_q & match & wen_q));
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (int'(bus_addr) < NWORD)
      bus_rdata = req_q[int'(bus_addr)*DW +: DW];
    else if (bus_addr >= A_ACK && int'(bus_addr - A_ACK) < NWORD)
      bus_rdata = ack_q[int'(bus_addr - A_ACK)*DW +: DW];
    else if (bus_addr == A_CTRL)
      bus_rdata = DW'(ctrl_q);
    else if (bus_addr >= A_SEEN && int'(bus_addr - A_SEEN) < NWORD)
      bus_rdata = seen_w[int'(bus_addr - A_SEEN)*DW +: DW];
  end

  assert_pull_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pu_q & pd_q) == '0);
  assert_seen_needs_wen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((seen_q & ~$past(seen_q)) & ~$past(wen_q)) == '0);
  assert_seen_needs_match_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((seen_q & ~$past(seen_q)) & ~$past(match)) == '0);
  assert_ev_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ev_clr |=> seen_q == '0);
  assert_cfg_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_clr |=> (wen_q == '0 && pu_q == '0 && pd_q == '0 && actlo_q == '0));
  assert_pulse_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((p0 || p1) && !ctrl_q[15]) |=> ($stable(wen_q) && $stable(actlo_q) && $stable(pu_q) && $stable(pd_q)));
endmodule

// File: tb/tb_pad_wake_cfg.sv
module tb_pad_wake_cfg;
  localparam int NPAD = 72;
  logic clk = 0, rst_n = 0, bus_wr = 0;
  logic [3:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic [NPAD-1:0] pad_in = 0, seen, pull_up, pull_dn;
  logic wake;
  int tests = 0, fails = 0;
  bit chk_on = 0;

  pad_wake_cfg dut (.clk, .rst_n, .bus_wr, .bus_addr, .bus_wdata, .bus_rdata,
                    .pad_in, .wake, .seen, .pull_up, .pull_dn);

  always #5 clk = ~clk;

  logic [95:0] m_req = 0, m_ack = 0;
  logic [15:0] m_ctrl = 0;
  logic [NPAD-1:0] m_wen = 0, m_lo = 0, m_pu = 0, m_pd = 0, m_seen = 0, m_hit = 0;

  always @(posedge clk) if (rst_n) begin
    logic [NPAD-1:0] mt, oh;
    logic [7:0] s;
    logic g;
    mt = pad_in ^ m_lo;
    s = m_ctrl[7:0];
    g = m_ctrl[15] && s < NPAD && m_req[s] && m_ack[(s/32)*32 +: 32] == m_req[(s/32)*32 +: 32]
        && bus_wr && (bus_addr == 9 || bus_addr == 10);
    oh = g ? (NPAD'(1) << s) : '0;
    if (bus_wr && bus_addr == 15 && bus_wdata[0]) m_seen = 0;
    else m_seen = m_seen | (m_hit & mt & m_wen);
    m_hit = mt & m_wen;
    m_ack = m_req;
    if (bus_wr && bus_addr < 3) m_req[bus_addr*32 +: 32] = bus_wdata;
    if (bus_wr && bus_addr == 8) m_ctrl = bus_wdata[15:0];
    if (bus_wr && bus_addr == 15 && bus_wdata[1]) begin
      m_wen = 0; m_lo = 0; m_pu = 0; m_pd = 0;
    end else if (g) begin
      case (m_ctrl[9:8])
        0: m_lo = bus_addr == 10 ? (m_lo | oh) : (m_lo & ~oh);
        1: m_wen = bus_addr == 10 ? (m_wen | oh) : (m_wen & ~oh);
        2: begin
          m_pu = bus_addr == 9 ? (m_pu | oh) : (m_pu & ~oh);
          m_pd = bus_addr == 10 ? (m_pd | oh) : (m_pd & ~oh);
        end
        default: ;
      endcase
    end
  end

  task automatic check(string req, logic [127:0] act, logic [127:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) if (chk_on) begin
    check("R7 seen", seen, m_seen);
    check("R9 wake", wake, |m_seen);
    check("R6 pull_up", pull_up, m_pu);
    check("R6 pull_dn", pull_dn, m_pd);
  end

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1 bus_wr = 0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; #1 d = bus_rdata;
  endtask

  task automatic cfg(int pad, int mode, int pulse);
    wr(8, 32'h8000 | (mode << 8) | pad);
    wr(pulse ? 10 : 9, 0);
    wr(8, 0);
  endtask

  function automatic logic [31:0] seen_word(logic [NPAD-1:0] v, int w);
    logic [95:0] f = 96'(v);
    return f[w*32 +: 32];
  endfunction

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    void'($urandom(1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 seen", seen, 0); check("R1 wake", wake, 0);
    check("R1 pull", {pull_up, pull_dn}, 0);
    rd(0, d); check("R1 req0", d, 0);
    rd(8, d); check("R1 ctrl", d, 0);

    // R2 ack trails request; R3 immediate pulse is busy
    wr(8, 32'h8000 | (2 << 8) | 43);      // port5 pin3, pull mode
    wr(1, 32'h0000_0800);                 // port5 -> word1 bits 15:8, pin3 -> bit 11
    wr(9, 0);
    rd(5, d); check("R2 ack trails", d, 32'h0000_0800);
    check("R3 busy pulse ignored", pull_up[43], 0);
    wr(9, 0);
    @(negedge clk); check("R6 pull-up set", pull_up[43], 1);
    wr(10, 0);
    @(negedge clk); check("R6 pull-down replaces up", {pull_up[43], pull_dn[43]}, 2'b01);
    wr(8, 0);
    wr(9, 0);
    @(negedge clk); check("R3 enable clear ignored", pull_dn[43], 1);

    // R3 pad not requested
    wr(8, 32'h8000 | (2 << 8) | 44);
    wr(9, 0);
    @(negedge clk); check("R3 unrequested pad ignored", pull_up[44], 0);
    wr(8, 32'h8000 | (2 << 8) | 100);
    wr(9, 0);
    @(negedge clk); check("R3 index out of range", pull_up, 0);

    // grant all pads
    wr(0, 32'hffff_ffff); wr(1, 32'hffff_ffff); wr(2, 32'h0000_00ff);
    repeat (2) @(negedge clk);
    rd(6, d); check("R2 ack word2", d, 32'h0000_00ff);

    // R11 mode 3 ignored
    cfg(67, 3, 1);
    @(negedge clk); check("R11 mode3 no effect", {pull_up[67], pull_dn[67]}, 0);

    // R5 + R7 port8 pin3, active high
    chk_on = 1;
    cfg(67, 1, 1);
    @(negedge clk); pad_in[67] = 1;
    @(negedge clk); pad_in[67] = 0;
    @(negedge clk); check("R7 single match ignored", seen[67], 0);
    pad_in[67] = 1;
    repeat (2) @(negedge clk);
    check("R5 R7 two matches set seen", seen[67], 1);
    check("R9 wake high", wake, 1);
    rd(14, d); check("R8 seen word2 bit3", d, 32'h0000_0008);
    pad_in[67] = 0;
    wr(15, 1);
    @(negedge clk); check("R10 event clear", seen, 0);

    // R4 active low on pad 67
    cfg(67, 0, 1);
    repeat (3) @(negedge clk);
    check("R4 active-low seen", seen[67], 1);
    wr(15, 1);
    cfg(67, 0, 0); cfg(67, 1, 0);
    wr(15, 1);
    repeat (3) @(negedge clk);
    check("R5 disabled pad no seen", seen[67], 0);

    // random phase
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      pad_in = {$urandom, $urandom, $urandom};
      if ($urandom_range(0, 5) == 0) cfg($urandom_range(0, NPAD-1), $urandom_range(0, 3), $urandom_range(0, 1));
      if ($urandom_range(0, 30) == 0) wr(15, 1);
      if ($urandom_range(0, 80) == 0) wr(15, 2);
    end
    for (int w = 0; w < 3; w++) begin
      rd(4'(12 + w), d); check("R8 seen readback", d, seen_word(m_seen, w));
    end
    wr(15, 3);
    @(negedge clk); check("R10 config clear", {pull_up, pull_dn}, 0);
    rd(0, d); check("R10 request kept", d, 32'hffff_ffff);
    chk_on = 0;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule